// File: doc/BRIEF.md
# Condition-driven lane pick unit

This block assembles a 32-bit word by taking each lane from one of two source operands. Which operand feeds a lane is not encoded in the instruction. It comes from a small field of condition bits that an earlier compare operation left in the control register. The unit receives that field as an input and only reads it. It never produces or changes condition bits.

Two lane formats exist. With the byte format, the word is split into four 8-bit lanes and all four condition bits are used. With the halfword format, the word is split into two 16-bit lanes and only the two lowest condition bits are used. The 32-bit result is sign-extended to the register width. It is then presented one clock later with a register write enable and a destination index. A request that names register index 0 is discarded. A request that carries a function code for neither format is also discarded.

Top module: `lane_pick_unit`

## Requirements
- R1: After reset `wr_en_o` is 0, `wr_idx_o` is 0 and `result_o` is all zeros.
- R2: Function code 5'h03 selects the byte format: for lane i (0..3, bits 8i+7:8i) the result lane equals the `opa_i` lane when `cond_i[i]` is 1 and the `opb_i` lane when it is 0.
- R3: Function code 5'h0B selects the halfword format: for lane i (0..1, bits 16i+15:16i) the result lane equals the `opa_i` lane when `cond_i[i]` is 1, else the `opb_i` lane; `cond_i[3:2]` have no effect on the result.
- R4: `result_o` bits XLEN-1:32 all equal bit 31 of the picked word.
- R5: A request with `dest_i` equal to 0 leaves `wr_en_o` at 0 in the following cycle and leaves `result_o` unchanged.
- R6: A request whose function code is neither 5'h03 nor 5'h0B, or a cycle with `valid_i` low, leaves `wr_en_o` at 0 in the following cycle and leaves `result_o` unchanged.
- R7: An accepted pick (valid, known function code, nonzero destination) raises `wr_en_o` exactly one clock later, with `wr_idx_o` equal to the request's `dest_i`.
- R8: `result_o` changes only in the cycle that follows an accepted pick; it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | A pick request is present this cycle |
| func_i | input | 5 | Function code: 5'h03 byte pick, 5'h0B halfword pick |
| dest_i | input | 5 | Destination register index |
| opa_i | input | 32 | Operand chosen where the condition bit is 1 |
| opb_i | input | 32 | Operand chosen where the condition bit is 0 |
| cond_i | input | 4 | Condition bits from the control register (lane 0 in bit 0) |
| wr_en_o | output | 1 | Register write enable |
| wr_idx_o | output | 5 | Register index for the write |
| result_o | output | XLEN (64) | Sign-extended pick result |

## Verification
A wrong lane select or a wrong lane boundary shows in `result_o` one clock after the request, in the lane concerned. So the condition patterns all-ones, all-zeros and the two alternating forms are applied under both formats, with operands whose lanes are distinct. A stuck or wrongly gated write enable shows in the same cycle as a spurious or missing `wr_en_o`. A result register that updates when it should not shows as a changed `result_o` after a discarded request. That case is exposed by discarded requests whose operands differ from the last accepted pick.

// File: rtl/lane_pick_pkg.sv
package lane_pick_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned FUNC_W = 5;
    localparam int unsigned IDX_W  = 5;
    localparam int unsigned COND_W = 4;

    localparam logic [FUNC_W-1:0] FUNC_PICK_BYTE = 5'h03;
    localparam logic [FUNC_W-1:0] FUNC_PICK_HALF = 5'h0B;

    typedef enum logic [1:0] {
        FMT_NONE = 2'd0,
        FMT_BYTE = 2'd1,
        FMT_HALF = 2'd2
    } pick_fmt_e;

endpackage

// File: rtl/lane_pick_decode.sv
module lane_pick_decode
    import lane_pick_pkg::*;
(
    input  logic              valid_i,
    input  logic [FUNC_W-1:0] func_i,
    input  logic [IDX_W-1:0]  dest_i,
    output pick_fmt_e         fmt_o,
    output logic              accept_o
);

    always_comb begin
        fmt_o = FMT_NONE;
        unique case (func_i)
            FUNC_PICK_BYTE: fmt_o = FMT_BYTE;
            FUNC_PICK_HALF: fmt_o = FMT_HALF;
            default:        fmt_o = FMT_NONE;
        endcase
    end

    // A write to index 0 is meaningless, so the request is dropped.
    assign accept_o = valid_i && (fmt_o != FMT_NONE) && (dest_i != '0);

endmodule

// File: rtl/lane_pick_mux.sv
module lane_pick_mux #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned SEL_W  = 4
) (
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int unsigned N_LANES = WORD_W / LANE_W;

    generate
        for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            assign word_o[g*LANE_W +: LANE_W] =
                sel_i[g] ? opa_i[g*LANE_W +: LANE_W] : opb_i[g*LANE_W +: LANE_W];
        end
    endgenerate

endmodule

// File: rtl/lane_pick_unit.sv
module lane_pick_unit
    import lane_pick_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [4:0]        func_i,
    input  logic [4:0]        dest_i,
    input  logic [31:0]       opa_i,
    input  logic [31:0]       opb_i,
    input  logic [3:0]        cond_i,
    output logic              wr_en_o,
    output logic [4:0]        wr_idx_o,
    output logic [XLEN-1:0]   result_o
);

    localparam int unsigned EXT_W = XLEN - WORD_W;

    typedef struct packed {
        logic             wr_en;
        logic [IDX_W-1:0] wr_idx;
        logic [XLEN-1:0]  result;
    } out_state_t;

    out_state_t state_d, state_q;

    pick_fmt_e         fmt;
    logic              accept;
    logic [WORD_W-1:0] byte_word;
    logic [WORD_W-1:0] half_word;
    logic [WORD_W-1:0] picked;
    logic [XLEN-1:0]   picked_ext;

    lane_pick_decode u_decode (
        .valid_i  (valid_i),
        .func_i   (func_i),
        .dest_i   (dest_i),
        .fmt_o    (fmt),
        .accept_o (accept)
    );

    lane_pick_mux #(
        .WORD_W (WORD_W),
        .LANE_W (8),
        .SEL_W  (4)
    ) u_mux_byte (
        .opa_i  (opa_i),
        .opb_i  (opb_i),
        .sel_i  (cond_i),
        .word_o (byte_word)
    );

    lane_pick_mux #(
        .WORD_W (WORD_W),
        .LANE_W (16),
        .SEL_W  (2)
    ) u_mux_half (
        .opa_i  (opa_i),
        .opb_i  (opb_i),
        .sel_i  (cond_i[1:0]),
        .word_o (half_word)
    );

    assign picked = (fmt == FMT_HALF) ? half_word : byte_word;

    generate
        if (EXT_W > 0) begin : g_sext
            assign picked_ext = {{EXT_W{picked[WORD_W-1]}}, picked};
        end else begin : g_nosext
            assign picked_ext = picked;
        end
    endgenerate

    always_comb begin
        state_d       = state_q;
        state_d.wr_en = accept;
        if (accept) begin
            state_d.wr_idx = dest_i;
            state_d.result = picked_ext;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign wr_en_o  = state_q.wr_en;
    assign wr_idx_o = state_q.wr_idx;
    assign result_o = state_q.result;

endmodule

// File: rtl/lane_pick_unit_chk.sv
module lane_pick_unit_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            valid_i,
    input logic [4:0]      func_i,
    input logic [4:0]      dest_i,
    input logic [31:0]     opa_i,
    input logic [31:0]     opb_i,
    input logic [3:0]      cond_i,
    input logic            wr_en_o,
    input logic [4:0]      wr_idx_o,
    input logic [XLEN-1:0] result_o
);

    logic known_func;
    logic fire;
    assign known_func = (func_i == 5'h03) || (func_i == 5'h0B);
    assign fire       = valid_i && known_func && (dest_i != 5'd0);

    // R5: index 0 never produces a write
    a_r5_zero_dest_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && dest_i == 5'd0) |=> !wr_en_o);

    // R6: unknown function codes never produce a write
    a_r6_unknown_func_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !known_func) |=> !wr_en_o);

    // R7: accepted pick writes next cycle to the requested index
    a_r7_write_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire |=> (wr_en_o && wr_idx_o == $past(dest_i)));

    // R8: result holds unless a pick was accepted
    a_r8_result_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fire |=> $stable(result_o));

    // R4: upper bits replicate bit 31
    a_r4_sign_extended: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (XLEN <= 32) || ($countones(result_o[XLEN-1:31]) == 0)
        || ($countones(result_o[XLEN-1:31]) == XLEN - 31));

    // R2: byte lane 0 follows its condition bit
    a_r2_byte_lane0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire && func_i == 5'h03) |=>
        (result_o[7:0] == ($past(cond_i[0]) ? $past(opa_i[7:0]) : $past(opb_i[7:0]))));

    // R3: halfword lane 1 follows condition bit 1
    a_r3_half_lane1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire && func_i == 5'h0B) |=>
        (result_o[31:16] == ($past(cond_i[1]) ? $past(opa_i[31:16]) : $past(opb_i[31:16]))));

endmodule

bind lane_pick_unit lane_pick_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .func_i   (func_i),
    .dest_i   (dest_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .cond_i   (cond_i),
    .wr_en_o  (wr_en_o),
    .wr_idx_o (wr_idx_o),
    .result_o (result_o)
);

// File: tb/lane_pick_unit_tb.sv
module lane_pick_unit_tb;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid = 1'b0;
    logic [4:0]      func = '0;
    logic [4:0]      dest = '0;
    logic [31:0]     opa = '0;
    logic [31:0]     opb = '0;
    logic [3:0]      cond = '0;
    logic            wr_en;
    logic [4:0]      wr_idx;
    logic [XLEN-1:0] result;

    int n_vec = 0;
    int n_bad = 0;

    // Reference state
    logic            m_en = 1'b0;
    logic [4:0]      m_idx = '0;
    logic [XLEN-1:0] m_res = '0;

    always #2.5 clk = ~clk;

    lane_pick_unit #(.XLEN(XLEN)) u_dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .valid_i  (valid),
        .func_i   (func),
        .dest_i   (dest),
        .opa_i    (opa),
        .opb_i    (opb),
        .cond_i   (cond),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .result_o (result)
    );

    function automatic logic [31:0] pick_word(input logic [31:0] a, input logic [31:0] b,
                                              input logic [3:0] c, input int lane_bits);
        logic [31:0] w = '0;
        int lanes = 32 / lane_bits;
        for (int i = 0; i < lanes; i++)
            for (int k = 0; k < lane_bits; k++)
                w[i*lane_bits + k] = c[i] ? a[i*lane_bits + k] : b[i*lane_bits + k];
        return w;
    endfunction

    task automatic compare(input string tag);
        n_vec++;
        if (wr_en !== m_en || wr_idx !== m_idx || result !== m_res) begin
            n_bad++;
            $display("FAIL %s: actual en=%0b idx=%0d res=%h expected en=%0b idx=%0d res=%h",
                     tag, wr_en, wr_idx, result, m_en, m_idx, m_res);
        end
    endtask

    // Drive at negedge, model at posedge, compare at the following negedge.
    task automatic step(input logic v, input logic [4:0] f, input logic [4:0] d,
                        input logic [31:0] a, input logic [31:0] b, input logic [3:0] c,
                        input string tag);
        logic [31:0] w;
        valid = v; func = f; dest = d; opa = a; opb = b; cond = c;
        @(posedge clk);
        m_en = 1'b0;
        if (v && d != 0 && (f == 5'h03 || f == 5'h0B)) begin
            w = pick_word(a, b, c, (f == 5'h03) ? 8 : 16);
            m_en  = 1'b1;
            m_idx = d;
            m_res = {{32{w[31]}}, w};
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic [3:0] pats [4];
        pats[0] = 4'hF; pats[1] = 4'h0; pats[2] = 4'h5; pats[3] = 4'hA;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R2 byte format, all condition patterns
        foreach (pats[p])
            step(1, 5'h03, 5'd7, 32'h8899AABB, 32'h11223344, pats[p], "R2 byte pattern");
        // R3 halfword format, all patterns; upper cond bits must not matter
        foreach (pats[p])
            step(1, 5'h0B, 5'd9, 32'hF00D1234, 32'h5678BEEF, pats[p], "R3 half pattern");
        step(1, 5'h0B, 5'd9, 32'hF00D1234, 32'h5678BEEF, 4'b1101, "R3 cond upper ignored");
        step(1, 5'h0B, 5'd9, 32'hF00D1234, 32'h5678BEEF, 4'b0001, "R3 cond upper ignored");

        // R4 sign extension both polarities
        step(1, 5'h03, 5'd3, 32'h80000000, 32'h00000000, 4'h8, "R4 negative");
        step(1, 5'h03, 5'd3, 32'h80000000, 32'h7FFFFFFF, 4'h0, "R4 positive");

        // R5 dest 0 dropped, result held (R8)
        step(1, 5'h03, 5'd0, 32'hDEADBEEF, 32'hCAFEF00D, 4'hF, "R5 zero dest");
        step(1, 5'h0B, 5'd0, 32'h01234567, 32'h89ABCDEF, 4'h3, "R5 zero dest half");

        // R6 unknown function codes and idle
        for (int f = 0; f < 32; f++)
            if (f != 3 && f != 11)
                step(1, f[4:0], 5'd12, 32'hA5A5A5A5, 32'h5A5A5A5A, 4'h6, "R6 unknown func");
        step(0, 5'h03, 5'd12, 32'hA5A5A5A5, 32'h5A5A5A5A, 4'h6, "R6 idle");

        // R7 back-to-back picks with varying indices, R8 hold between them
        for (int i = 1; i < 32; i++) begin
            step(1, (i % 2) ? 5'h03 : 5'h0B, i[4:0], 32'h13579BDF * i, 32'h2468ACE0 ^ i,
                 i[3:0], "R7 index");
            step(0, 5'h0B, i[4:0], ~opa, ~opb, ~cond, "R8 hold");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule